// File: doc/BRIEF.md
# Dual-Hart Machine Timer

This peripheral serves a system with two harts and one shared notion of time. It keeps one free-running 64-bit tick counter. It also keeps one 64-bit deadline register for each hart. Software reaches every register as two 32-bit word halves over a simple request/response register bus. The bus answers each request exactly one cycle later, with read data or an error flag.

Each hart gets its own level-sensitive timer interrupt bit. A bit is high while the counter has reached or passed that hart's deadline, using an unsigned comparison. It stays high until software moves the deadline beyond the current count, or moves the count back below the deadline. The interrupt bits are registered. They follow a counter or deadline change one cycle later.

The hart count, the data width and the base address are parameters. The offsets below are given relative to `BASE_ADDR`, which defaults to zero.

Top module: `twin_hart_timer`

## Requirements
- R1: In every cycle that carries no write to the counter, the 64-bit counter advances by exactly one, and the carry passes from bit 31 into bit 32.
- R2: The register offsets are fixed as follows. Counter: low word at 0x100, high word at 0x104. Hart 0 deadline: 0x108 low, 0x10c high. Hart 1 deadline: 0x110 low, 0x114 high. An offset matches only when its bits 1:0 are zero.
- R3: A write to a low-word offset replaces bits 31:0 and keeps bits 63:32. A write to a high-word offset replaces bits 63:32 and keeps bits 31:0. The new value is in place from the next cycle.
- R4: Every request cycle is followed, in the next cycle, by exactly one cycle of `rspValid`, and no other cycle has `rspValid` high. A read returns the chosen word half as it stood in the request cycle. A successful write returns zero data.
- R5: A request to any offset other than those in R2 gets `rspErr` high and `rspData` zero, and it changes no register.
- R6: A write to the counter overrides that cycle's increment. The counter holds the merged written value in the following cycle, then counts on from it.
- R7: `timerIrq[h]` in cycle t+1 equals (counter >= deadline h), compared as unsigned 64-bit values from cycle t.
- R8: Each interrupt bit depends only on its own hart's deadline. A deadline changes only when its own offsets are written.
- R9: Reset, which is synchronous and active high, clears the counter and both deadlines to zero and drives both interrupt bits high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Bus request present this cycle |
| reqWrite | input | 1 | Request is a write (1) or read (0) |
| reqAddr | input | 32 | Byte address of the word accessed |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspErr | output | 1 | Previous request hit no register |
| rspData | output | 32 | Read data (zero for writes and errors) |
| timerIrq | output | 2 | Per-hart timer interrupt, level-sensitive |

## Verification
The embedded properties check the following on every cycle:
- The counter steps by one whenever it is not being written.
- The written value wins over the increment.
- The untouched half and the deadlines of other harts hold their values.
- Responses are spaced one per request.
- An error response carries no data.

The bench's scenarios are needed for the rest:
- Exact address decoding across the whole offset window, including misaligned and neighbouring offsets.
- The carry from the low word into the high word.
- The unsigned comparison when a deadline has its top bit set.
- The one-cycle lag of the interrupt bits, which a reference model traces cycle by cycle.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  localparam int REG_IDX_W = 4;

  typedef struct packed {
    logic                 rdEn;
    logic                 wrEn;
    logic                 hiHalf;
    logic [REG_IDX_W-1:0] regIdx;
  } tmr_strobe_t;

endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_HART    = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output tmr_strobe_t       strobe,
  output logic              rspValid,
  output logic              rspErr
);

  localparam int N_REGS    = N_HART + 1;
  localparam int FIRST_OFF = 'h100;
  localparam int SPAN      = N_REGS * 8;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] relOff;
  logic              inWindow;
  logic              aligned;
  logic              regHit;

  assign offset   = reqAddr - BASE_ADDR;
  assign relOff   = offset - ADDR_W'(FIRST_OFF);
  assign inWindow = (offset >= ADDR_W'(FIRST_OFF)) &&
                    (offset <  ADDR_W'(FIRST_OFF + SPAN));
  assign aligned  = (offset[1:0] == 2'b00);
  assign regHit   = inWindow && aligned;

  always_comb begin
    strobe.rdEn   = reqValid && regHit && !reqWrite;
    strobe.wrEn   = reqValid && regHit &&  reqWrite;
    strobe.hiHalf = relOff[2];
    strobe.regIdx = relOff[3 +: REG_IDX_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !regHit;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid); // R4
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid); // R4
  AST_ERR_IN_RSP: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> rspValid); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strobe.rdEn && strobe.wrEn)); // R2

endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_HART = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [N_HART-1:0] timerIrq
);

  localparam int CNT_W  = 2 * DATA_W;
  localparam int N_REGS = N_HART + 1;

  // index 0 is the tick counter, index h+1 is hart h's deadline
  logic [CNT_W-1:0]  regQ [N_REGS];
  logic [CNT_W-1:0]  timeNext;
  logic [DATA_W-1:0] rdSel;

  function automatic logic [CNT_W-1:0] mergeHalf(
    input logic [CNT_W-1:0]  cur,
    input logic              hi,
    input logic [DATA_W-1:0] d
  );
    return hi ? {d, cur[DATA_W-1:0]} : {cur[CNT_W-1:DATA_W], d};
  endfunction

  always_comb begin
    if (strobe.wrEn && strobe.regIdx == '0)
      timeNext = mergeHalf(regQ[0], strobe.hiHalf, wrData);
    else
      timeNext = regQ[0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N_REGS; r++) regQ[r] <= '0;
    end else begin
      regQ[0] <= timeNext;
      for (int r = 1; r < N_REGS; r++) begin
        if (strobe.wrEn && strobe.regIdx == REG_IDX_W'(r))
          regQ[r] <= mergeHalf(regQ[r], strobe.hiHalf, wrData);
      end
    end
  end

  always_comb begin
    rdSel = '0;
    for (int r = 0; r < N_REGS; r++) begin
      if (strobe.regIdx == REG_IDX_W'(r))
        rdSel = strobe.hiHalf ? regQ[r][CNT_W-1:DATA_W] : regQ[r][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= strobe.rdEn ? rdSel : '0;
  end

  generate
    for (genvar h = 0; h < N_HART; h++) begin : g_hart
      always_ff @(posedge clk) begin
        if (rst) timerIrq[h] <= 1'b1;
        else     timerIrq[h] <= (regQ[0] >= regQ[h+1]);
      end

      AST_DEADLINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(strobe.wrEn && strobe.regIdx == REG_IDX_W'(h+1)) |=> $stable(regQ[h+1])); // R8
      AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (strobe.wrEn && !strobe.hiHalf && strobe.regIdx == REG_IDX_W'(h+1))
        |=> regQ[h+1][CNT_W-1:DATA_W] == $past(regQ[h+1][CNT_W-1:DATA_W])); // R3
      AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (strobe.wrEn && strobe.hiHalf && strobe.regIdx == REG_IDX_W'(h+1))
        |=> regQ[h+1][DATA_W-1:0] == $past(regQ[h+1][DATA_W-1:0])); // R3
    end
  endgenerate

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    !(strobe.wrEn && strobe.regIdx == '0) |=> regQ[0] == $past(regQ[0]) + 1'b1); // R1
  AST_TIME_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn && strobe.regIdx == '0 && !strobe.hiHalf)
    |=> regQ[0][DATA_W-1:0] == $past(wrData)); // R6

endmodule

// File: rtl/twin_hart_timer.sv
module twin_hart_timer
  import twin_timer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_HART = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic [N_HART-1:0] timerIrq
);

  tmr_strobe_t strobe;

  twin_timer_ctrl #(
    .ADDR_W    (ADDR_W),
    .N_HART    (N_HART),
    .BASE_ADDR (BASE_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  twin_timer_dp #(
    .DATA_W (DATA_W),
    .N_HART (N_HART)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (reqWdata),
    .rdData   (rspData),
    .timerIrq (timerIrq)
  );

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rspErr |-> rspData == '0); // R5

endmodule

// File: tb/twin_hart_timer_tb_top.sv
module twin_hart_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspData;
  logic [1:0]  timerIrq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic started = 1'b0;

  always #5 clk = ~clk;

  twin_hart_timer dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .timerIrq(timerIrq)
  );

  // Reference model built from the requirements
  logic [63:0] mReg [3];
  logic [1:0]  mIrq;
  logic        mRspV, mRspE;
  logic [31:0] mRspD;

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 3; r++) mReg[r] <= '0;
      mIrq <= 2'b11; mRspV <= 1'b0; mRspE <= 1'b0; mRspD <= '0;
    end else begin
      automatic logic        hit = (reqAddr >= 32'h100) && (reqAddr < 32'h118) && (reqAddr[1:0] == 2'b00);
      automatic int          idx = int'((reqAddr - 32'h100) >> 3);
      automatic logic        hi  = reqAddr[2];
      automatic logic [63:0] nt  = mReg[0] + 64'd1;
      automatic logic [63:0] cur;
      for (int h = 0; h < 2; h++) mIrq[h] <= (mReg[0] >= mReg[h+1]);
      mRspV <= reqValid;
      mRspE <= reqValid && !hit;
      mRspD <= '0;
      if (reqValid && hit) begin
        cur = mReg[idx];
        if (!reqWrite) mRspD <= hi ? cur[63:32] : cur[31:0];
        else begin
          cur = hi ? {reqWdata, cur[31:0]} : {cur[63:32], reqWdata};
          if (idx == 0) nt = cur;
          else mReg[idx] <= cur;
        end
      end
      mReg[0] <= nt;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R7 irq", {62'd0, timerIrq}, {62'd0, mIrq});
      chk("R4 rspValid", {63'd0, rspValid}, {63'd0, mRspV});
      if (mRspV) begin
        chk("R5 rspErr", {63'd0, rspErr}, {63'd0, mRspE});
        chk(mRspE ? "R5 rspData" : "R4 rspData", {32'd0, rspData}, {32'd0, mRspD});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic busWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [31:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    d = rspData; e = rspErr;
    reqValid = 1'b0;
  endtask

  initial begin
    logic [31:0] d0, d1;
    logic e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    started = 1'b1;

    // R9: reset state
    chk("R9 irq out of reset", {62'd0, timerIrq}, 64'd3);
    busRead(32'h108, d0, e); chk("R9 deadline0 low", {32'd0, d0}, 64'd0);
    busRead(32'h114, d0, e); chk("R9 deadline1 high", {32'd0, d0}, 64'd0);

    // R1: two reads of the counter with one idle cycle between them
    busRead(32'h100, d0, e);
    busRead(32'h100, d1, e);
    chk("R1 step between reads", {32'd0, d1 - d0}, 64'd2);

    // R6: a written counter value wins over the increment
    busWrite(32'h100, 32'h0000_1234);
    busRead(32'h100, d0, e);
    chk("R6 counter after write", {32'd0, d0}, 64'h1235);

    // R3: independent halves
    busWrite(32'h10c, 32'hAAAA_0000);
    busWrite(32'h108, 32'h0000_5555);
    busRead(32'h10c, d0, e); chk("R3 high half", {32'd0, d0}, 64'hAAAA_0000);
    busWrite(32'h10c, 32'h0000_0001);
    busRead(32'h108, d0, e); chk("R3 low half kept", {32'd0, d0}, 64'h5555);

    // R7 and R8: unsigned compare with the top bit set, hart 1 unaffected
    busWrite(32'h10c, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R7 unsigned compare", {63'd0, timerIrq[0]}, 64'd0);
    chk("R8 hart1 independent", {63'd0, timerIrq[1]}, 64'd1);

    // R7: threshold crossing traced by the model
    busWrite(32'h10c, 32'h0);
    busWrite(32'h108, 32'd120);
    busWrite(32'h104, 32'h0);
    busWrite(32'h100, 32'd40);
    busWrite(32'h114, 32'h0);
    busWrite(32'h110, 32'd90);
    repeat (10) @(negedge clk);
    chk("R7 below deadline", {62'd0, timerIrq}, 64'd0);
    repeat (120) @(negedge clk);
    chk("R7 past deadline", {62'd0, timerIrq}, 64'd3);

    // R1: carry from the low word into the high word
    busWrite(32'h104, 32'h0);
    busWrite(32'h100, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    busRead(32'h104, d0, e);
    chk("R1 carry into high word", {32'd0, d0}, 64'd1);

    // R2 and R5: sweep of every byte offset around the window, reads then writes
    for (int a = 32'hF0; a < 32'h120; a++) begin
      automatic logic mapped = (a >= 32'h100) && (a < 32'h118) && (a[1:0] == 2'b00);
      busRead(a, d0, e);
      chk(mapped ? "R2 mapped read" : "R5 unmapped read", {63'd0, e}, {63'd0, !mapped});
    end
    for (int a = 32'hF0; a < 32'h120; a++) begin
      if (!((a >= 32'h100) && (a < 32'h118) && (a[1:0] == 2'b00)))
        busWrite(a, 32'hFFFF_FFFF);
    end
    for (int r = 32'h108; r < 32'h118; r += 4) begin
      busRead(r, d0, e);
      chk("R5 no change from unmapped writes", {32'd0, d0}, {32'd0, mReg[(r - 32'h100) >> 3][r[2] ? 32 : 0 +: 32]});
    end

    // R3 and R8: distinct patterns per deadline half
    for (int r = 32'h108; r < 32'h118; r += 4)
      busWrite(r, 32'hC0DE_0000 | r);
    for (int r = 32'h108; r < 32'h118; r += 4) begin
      busRead(r, d0, e);
      chk("R3 pattern readback", {32'd0, d0}, {32'd0, 32'hC0DE_0000 | r});
    end

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule